// File: doc/BRIEF.md
# Programmable LCD Timing Generator

This block generates the raster timing for a parallel RGB panel. It produces horizontal and vertical sync, a data-enable strobe, a pixel-clock output, the live pixel and line position, four display-phase status flags and a sticky line-interrupt flag. A horizontal counter and a vertical counter drive all of these. The horizontal counter steps on a pixel clock enable. The vertical counter steps each time the horizontal counter wraps.

Each axis is programmed as four cumulative boundaries, all written as a count minus one and all measured from the first cycle of the sync pulse. These are the sync end, the back-porch end, the active end and the line or frame total. A global enable starts the raster. When the enable is low, both counters are held at zero and every output sits at its inactive level.

Top module: `lcd_timing_gen`

## Requirements
- R1: While `enable` is low at a clock edge, both counters are zero after that edge, `pos_x`/`pos_y` read 0, all four status flags are 0, and `hsync`, `vsync`, `de` and `pclk_o` show their inactive levels.
- R2: With `enable` high, the horizontal position advances by one on each edge where `pix_ce` is high. After the edge where it equals `total_h` (or exceeds it), it returns to 0.
- R3: The vertical position advances by one only on the edge where the horizontal position wraps. If it equals `total_v` at that edge, it returns to 0 instead.
- R4: `st_hsync` is 1 while x <= `sync_h`, and `st_vsync` is 1 while y <= `sync_v` (counting starts at the first sync cycle).
- R5: `st_hde` is 1 while `bp_h` < x <= `act_h`, and `st_vde` is 1 while `bp_v` < y <= `act_v`.
- R6: The DE phase is active only when `st_hde` and `st_vde` are both 1.
- R7: Each of `hsync`, `vsync` and `de` has its own polarity bit. A polarity bit of 1 gives an active-high output, and 0 gives an active-low output.
- R8: `pclk_o` is a one-cycle-delayed copy of `enable & pix_ce`. It is inverted when `pol_pclk` is 0.
- R9: With `enable` high and `pix_ce` low, both positions hold their values.
- R10: `line_irq` is set on the edge after a cycle in which `enable` is high, x = 0 and y = `irq_line`. It stays set until an edge where `irq_clr` is high and no new set occurs; a set and a clear in the same cycle leave it set.
- R11: `pos_x` and `pos_y` are 16 bits wide, with the 12-bit counter zero-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Global raster enable |
| pix_ce | input | 1 | Pixel clock enable |
| sync_h | input | 12 | Horizontal sync width minus 1 |
| bp_h | input | 12 | Sync + back porch pixels minus 1 |
| act_h | input | 12 | Sync + back porch + active pixels minus 1 |
| total_h | input | 12 | Total pixels per line minus 1 |
| sync_v | input | 12 | Vertical sync height minus 1 |
| bp_v | input | 12 | Sync + back porch lines minus 1 |
| act_v | input | 12 | Sync + back porch + active lines minus 1 |
| total_v | input | 12 | Total lines per frame minus 1 |
| pol_hs | input | 1 | HSYNC polarity (1 = active high) |
| pol_vs | input | 1 | VSYNC polarity (1 = active high) |
| pol_de | input | 1 | DE polarity (1 = active high) |
| pol_pclk | input | 1 | Pixel clock output polarity |
| irq_line | input | 12 | Line that raises the line interrupt |
| irq_clr | input | 1 | Write-one clear of the line interrupt |
| hsync | output | 1 | Horizontal sync at selected polarity |
| vsync | output | 1 | Vertical sync at selected polarity |
| de | output | 1 | Data enable at selected polarity |
| pclk_o | output | 1 | Pixel clock strobe at selected polarity |
| pos_x | output | 16 | Current pixel position |
| pos_y | output | 16 | Current line position |
| st_vde | output | 1 | Vertical active phase flag |
| st_hde | output | 1 | Horizontal active phase flag |
| st_vsync | output | 1 | Vertical sync phase flag |
| st_hsync | output | 1 | Horizontal sync phase flag |
| line_irq | output | 1 | Sticky line interrupt flag |

## Verification
The counters, `pclk_o` and `line_irq` are registers, so each reflects the inputs seen at the preceding edge, one cycle after the stimulus. The sync, DE and status outputs are decoded combinationally from the counters and the live configuration, so they follow the counter state in the same cycle. The bench changes inputs only at the falling edge and advances a reference model of both counters, the strobe and the interrupt flag with those inputs. At the next falling edge it compares every output against that model, which keeps each result aligned to its one-edge latency.

// File: rtl/lcdtg_pkg.sv
package lcdtg_pkg;
  localparam int unsigned CNT_W = 12;
  localparam int unsigned POS_W = 16;

  typedef struct packed {
    logic sync;
    logic act;
  } axis_phase_t;
endpackage

// File: rtl/lcdtg_axis.sv
module lcdtg_axis
  import lcdtg_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         step,
  input  logic [W-1:0] sync_end,
  input  logic [W-1:0] bp_end,
  input  logic [W-1:0] act_end,
  input  logic [W-1:0] total,
  output logic [W-1:0] cnt,
  output logic         wrap,
  output axis_phase_t  phase
);
  logic [W-1:0] cnt_d;

  assign wrap = run && step && (cnt >= total);

  always_comb begin
    cnt_d = cnt;
    if (!run)       cnt_d = '0;
    else if (wrap)  cnt_d = '0;
    else if (step)  cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  always_comb begin
    phase.sync = run && (cnt <= sync_end);
    phase.act  = run && (cnt > bp_end) && (cnt <= act_end);
  end

  // R1
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt == '0);
  // R2
  step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && step && cnt < total) |=> cnt == $past(cnt) + 1'b1);
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !step) |=> $stable(cnt));
endmodule

// File: rtl/lcdtg_irq.sv
module lcdtg_irq
  import lcdtg_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] target,
  input  logic         clr,
  output logic         flag
);
  logic hit, flag_d;

  assign hit = run && (x == '0) && (y == target);

  always_comb begin
    flag_d = flag;
    if (clr) flag_d = 1'b0;
    if (hit) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= flag_d;
  end

  // R10
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
  // R10
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> ($past(y) == $past(target) && $past(x) == '0));
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcdtg_pkg::*;
#(
  parameter int unsigned W  = CNT_W,
  parameter int unsigned PW = POS_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          pix_ce,
  input  logic [W-1:0]  sync_h,
  input  logic [W-1:0]  bp_h,
  input  logic [W-1:0]  act_h,
  input  logic [W-1:0]  total_h,
  input  logic [W-1:0]  sync_v,
  input  logic [W-1:0]  bp_v,
  input  logic [W-1:0]  act_v,
  input  logic [W-1:0]  total_v,
  input  logic          pol_hs,
  input  logic          pol_vs,
  input  logic          pol_de,
  input  logic          pol_pclk,
  input  logic [W-1:0]  irq_line,
  input  logic          irq_clr,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic          pclk_o,
  output logic [PW-1:0] pos_x,
  output logic [PW-1:0] pos_y,
  output logic          st_vde,
  output logic          st_hde,
  output logic          st_vsync,
  output logic          st_hsync,
  output logic          line_irq
);
  localparam int unsigned EXT = PW - W;

  logic [W-1:0] hcnt, vcnt;
  logic         hwrap, vwrap;
  axis_phase_t  hph, vph;
  logic         strobe_q, strobe_d;

  lcdtg_axis #(.W(W)) u_h (
    .clk(clk), .rst_n(rst_n), .run(enable), .step(pix_ce),
    .sync_end(sync_h), .bp_end(bp_h), .act_end(act_h), .total(total_h),
    .cnt(hcnt), .wrap(hwrap), .phase(hph)
  );

  lcdtg_axis #(.W(W)) u_v (
    .clk(clk), .rst_n(rst_n), .run(enable), .step(hwrap),
    .sync_end(sync_v), .bp_end(bp_v), .act_end(act_v), .total(total_v),
    .cnt(vcnt), .wrap(vwrap), .phase(vph)
  );

  lcdtg_irq #(.W(W)) u_irq (
    .clk(clk), .rst_n(rst_n), .run(enable), .x(hcnt), .y(vcnt),
    .target(irq_line), .clr(irq_clr), .flag(line_irq)
  );

  assign strobe_d = enable & pix_ce;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= strobe_d;
  end

  always_comb begin
    st_hsync = hph.sync;
    st_vsync = vph.sync;
    st_hde   = hph.act;
    st_vde   = vph.act;
    hsync    = st_hsync ? pol_hs : ~pol_hs;
    vsync    = st_vsync ? pol_vs : ~pol_vs;
    de       = (st_hde && st_vde) ? pol_de : ~pol_de;
    pclk_o   = strobe_q ? pol_pclk : ~pol_pclk;
    pos_x    = {{EXT{1'b0}}, hcnt};
    pos_y    = {{EXT{1'b0}}, vcnt};
  end

  // R3
  v_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !hwrap) |=> $stable(pos_y));
  // R3
  v_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && hwrap && vwrap) |=> pos_y == '0);
  // R2
  h_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && pix_ce && pos_x >= PW'(total_h)) |=> pos_x == '0);
  // R6
  de_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (de == pol_de) |-> (st_hde && st_vde));
  // R11
  pos_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pos_x[PW-1:W] == '0 && pos_y[PW-1:W] == '0);
endmodule

// File: tb/tb_lcd_timing_gen.sv
module tb_lcd_timing_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, pix_ce = 1'b0;
  logic [11:0] sync_h = '0, bp_h = '0, act_h = '0, total_h = '0;
  logic [11:0] sync_v = '0, bp_v = '0, act_v = '0, total_v = '0;
  logic pol_hs = 1'b1, pol_vs = 1'b1, pol_de = 1'b1, pol_pclk = 1'b1;
  logic [11:0] irq_line = '0;
  logic irq_clr = 1'b0;
  logic hsync, vsync, de, pclk_o, st_vde, st_hde, st_vsync, st_hsync, line_irq;
  logic [15:0] pos_x, pos_y;

  int checks = 0, fails = 0;
  int unsigned seed = 32'd1234;
  logic [11:0] mx = '0, my = '0;
  logic mstrobe = 1'b0, mirq = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lcd_timing_gen dut (.*);

  function automatic logic pol_out(input logic act, input logic pol);
    return act ? pol : ~pol;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    logic hs, vs, hd, vd;
    hs = enable_q && (mx <= sync_h);
    vs = enable_q && (my <= sync_v);
    hd = enable_q && (mx > bp_h) && (mx <= act_h);
    vd = enable_q && (my > bp_v) && (my <= act_v);
    chk("R2 pos_x", {16'h0, pos_x}, {20'h0, mx});
    chk("R3 pos_y", {16'h0, pos_y}, {20'h0, my});
    chk("R11 pos ext", {31'h0, (pos_x[15:12] == 0 && pos_y[15:12] == 0)}, 32'd1);
    chk("R4 st_hsync", {31'h0, st_hsync}, {31'h0, hs});
    chk("R4 st_vsync", {31'h0, st_vsync}, {31'h0, vs});
    chk("R5 st_hde", {31'h0, st_hde}, {31'h0, hd});
    chk("R5 st_vde", {31'h0, st_vde}, {31'h0, vd});
    chk("R7 hsync", {31'h0, hsync}, {31'h0, pol_out(hs, pol_hs)});
    chk("R7 vsync", {31'h0, vsync}, {31'h0, pol_out(vs, pol_vs)});
    chk("R6 de", {31'h0, de}, {31'h0, pol_out(hd && vd, pol_de)});
    chk("R8 pclk_o", {31'h0, pclk_o}, {31'h0, pol_out(mstrobe, pol_pclk)});
    chk("R10 line_irq", {31'h0, line_irq}, {31'h0, mirq});
  endtask

  // enable as seen at the last rising edge (counters reflect it)
  logic enable_q = 1'b0;

  // advance the reference with the inputs that the next rising edge sees
  task automatic model_step();
    logic hit;
    hit = enable && mx == 0 && my == irq_line;
    if (irq_clr) mirq = 1'b0;
    if (hit) mirq = 1'b1;
    mstrobe = enable & pix_ce;
    if (!enable) begin mx = 0; my = 0; end
    else if (pix_ce) begin
      if (mx >= total_h) begin
        mx = 0;
        if (my >= total_v) my = 0; else my = my + 1;
      end else mx = mx + 1;
    end
    enable_q = enable;
  endtask

  task automatic cycle(input logic en, input logic ce, input logic clr);
    enable = en; pix_ce = ce; irq_clr = clr;
    model_step();
    @(negedge clk);
    check_all();
  endtask

  task automatic rand_cfg();
    sync_h = 12'($urandom(seed) % 3);
    bp_h = sync_h + 12'(1 + $urandom % 3);
    act_h = bp_h + 12'(1 + $urandom % 5);
    total_h = act_h + 12'($urandom % 4);
    sync_v = 12'($urandom % 2);
    bp_v = sync_v + 12'(1 + $urandom % 3);
    act_v = bp_v + 12'(1 + $urandom % 4);
    total_v = act_v + 12'($urandom % 3);
    pol_hs = 1'($urandom); pol_vs = 1'($urandom);
    pol_de = 1'($urandom); pol_pclk = 1'($urandom);
    irq_line = 12'($urandom % (total_v + 1));
  endtask

  initial begin
    #100000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rand_cfg();
    repeat (3) @(negedge clk);
    // R1 reset state
    check_all();
    rst_n = 1'b1;
    @(negedge clk);
    check_all();
    for (int c = 0; c < 4; c++) begin
      rand_cfg();
      // R2 R9 random pix_ce, occasional R10 clear
      for (int i = 0; i < 1500; i++)
        cycle(1'b1, ($urandom % 4) != 0, ($urandom % 40) == 0);
      // R1 disable mid-frame: counters zero, outputs inactive
      cycle(1'b0, 1'b1, 1'b0);
      cycle(1'b0, 1'b1, 1'b1);
      cycle(1'b0, 1'b0, 1'b0);
    end
    // R10 set and clear in the same cycle: set wins
    irq_line = 12'd0;
    cycle(1'b1, 1'b0, 1'b1);
    cycle(1'b1, 1'b0, 1'b1);
    cycle(1'b1, 1'b1, 1'b0);
    // R10 clear once off the target line
    while (my == 0) cycle(1'b1, 1'b1, 1'b0);
    cycle(1'b1, 1'b1, 1'b1);
    cycle(1'b1, 1'b1, 1'b0);
    // R3 full frame wrap with pix_ce always high
    for (int i = 0; i < 600; i++) cycle(1'b1, 1'b1, 1'b0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule